// File: doc/BRIEF.md
# Fixed Off-Time Current Chopper

This block is the digital half of a current regulator for one H-bridge winding. While enabled, it keeps the bridge driving current forward. An external analog comparator reports when the winding current has reached its limit. When that happens, the block switches the bridge into a decay state for a fixed off-time, and then drives again. The result is a drive, trip, timed decay and re-drive loop. The chopping frequency comes from the winding and the supply, not from a fixed PWM clock.

The off-time is chosen by a 2-bit code that mirrors a four-level strap pin. The code selects 7, 16, 24 or 32 microseconds. The block turns this into a clock-cycle count using the `CLK_MHZ` parameter. The comparator signal is asynchronous to the block, so it passes through a synchronizer before use. Three mutually exclusive outputs tell the gate-drive logic whether to drive, decay or leave the bridge off. A one-cycle marker flags each new decay period.

Top module: `chop_ctrl`

## Requirements
- R1: While `en` is low, from the first clock edge after reset, the block is idle: `idle_on`=1, `drive_on`=0, `decay_on`=0. Dropping `en` in any state reaches idle on the next rising edge and clears the off-time counter.
- R2: With `en` high in idle, the next rising edge enters drive. Drive holds for as long as the synchronized trip stays low.
- R3: `trip_raw` passes through a two-flop synchronizer. A trip that first appears between two edges turns `decay_on` on at the third rising edge after it appears; `drive_on` stays on until then.
- R4: A decay period lasts exactly the selected number of clock cycles. Changes on the trip input during the period neither shorten nor lengthen it.
- R5: `toff_code` 0 selects 7 µs, 1 selects 16 µs, 2 selects 24 µs and 3 selects 32 µs. The period in cycles is the microsecond value times `CLK_MHZ`.
- R6: `toff_code` is captured only on the edge that starts a decay period. A change during a period takes effect from the next period.
- R7: When the off-time expires, the block returns to drive. If the synchronized trip is still high, it drives for exactly one cycle and then starts a new decay.
- R8: `decay_start` is high for exactly one clock, in the first cycle of each decay period, and at no other time.
- R9: While `en` is low, the trip input starts no decay. After re-enabling, the next decay runs its full length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock, frequency `CLK_MHZ` MHz |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Bridge enable, synchronous |
| trip_raw | input | 1 | Over-threshold flag from the current comparator, asynchronous |
| toff_code | input | 2 | Off-time selection code |
| drive_on | output | 1 | Bridge driving forward |
| decay_on | output | 1 | Bridge in decay |
| idle_on | output | 1 | All bridge switches off |
| decay_start | output | 1 | One-cycle marker for the first cycle of a decay |

## Verification
The in-RTL assertions check the cycle-to-cycle state rules on every clock. These rules are: idle after a disable, drive holding without a trip, decay holding while the counter runs, return to drive on expiry, the single-cycle start marker, and the counter bound. Other behaviour needs the bench scenarios. These cover the exact decay length for each code, the three-edge synchronizer latency, a code change during a period, the one-cycle re-drive under a held trip, and a decay cut short by a disable followed by a full-length restart. The scoreboard compares each measured decay length against the value computed for it.

// File: rtl/chop_pkg.sv
package chop_pkg;

   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_DRIVE = 2'd1,
      ST_DECAY = 2'd2
   } chop_st_e;

   localparam int unsigned TOFF_MAX_US = 32;

   // Off-time in microseconds for each strap code.
   function automatic int unsigned toff_us(input logic [1:0] code);
      case (code)
         2'd0:    return 7;
         2'd1:    return 16;
         2'd2:    return 24;
         default: return 32;
      endcase
   endfunction

endpackage

// File: rtl/chop_sync.sv
module chop_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic din,
   output logic dout
);

   if (STAGES < 2) begin : g_bad_stages
      $error("chop_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q[0] <= 1'b0;
      else        q[0] <= din;
   end

   for (genvar i = 1; i < STAGES; i++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) q[i] <= 1'b0;
         else        q[i] <= q[i-1];
      end
   end

   assign dout = q[STAGES-1];

endmodule

// File: rtl/chop_toff_timer.sv
module chop_toff_timer
   import chop_pkg::*;
#(
   parameter int CLK_MHZ = 50,
   parameter int CNT_W   = 11
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             load,
   input  logic [1:0]       code,
   output logic             done
);

   localparam int unsigned MAX_CYC = TOFF_MAX_US * CLK_MHZ;

   if (CLK_MHZ < 1) begin : g_bad_clk
      $error("chop_toff_timer: CLK_MHZ must be at least 1");
   end
   if ((2 ** CNT_W) < MAX_CYC) begin : g_bad_width
      $error("chop_toff_timer: CNT_W too narrow for longest off-time");
   end

   logic [CNT_W-1:0] cnt;
   logic [CNT_W-1:0] reload;

   always_comb begin
      reload = CNT_W'(toff_us(code) * CLK_MHZ - 1);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)           cnt <= '0;
      else if (clr)         cnt <= '0;
      else if (load)        cnt <= reload;
      else if (cnt != '0)   cnt <= cnt - 1'b1;
   end

   assign done = (cnt == '0);

   p_cnt_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
      32'(cnt) <= MAX_CYC - 1);

   p_clear_r1: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> done);

endmodule

// File: rtl/chop_fsm.sv
module chop_fsm
   import chop_pkg::*;
(
   input  logic     clk,
   input  logic     rst_n,
   input  logic     en,
   input  logic     trip_s,
   input  logic     tmr_done,
   output chop_st_e state,
   output logic     load,
   output logic     start_q
);

   chop_st_e state_d;

   always_comb begin
      state_d = state;
      if (!en) begin
         state_d = ST_IDLE;
      end else begin
         case (state)
            ST_IDLE:  state_d = ST_DRIVE;
            ST_DRIVE: if (trip_s)   state_d = ST_DECAY;
            ST_DECAY: if (tmr_done) state_d = ST_DRIVE;
            default:  state_d = ST_IDLE;
         endcase
      end
   end

   assign load = en && (state == ST_DRIVE) && trip_s;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state   <= ST_IDLE;
         start_q <= 1'b0;
      end else begin
         state   <= state_d;
         start_q <= load;
      end
   end

   p_idle_when_off_r1: assert property (@(posedge clk) disable iff (!rst_n)
      !en |=> state == ST_IDLE);

   p_drive_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (en && state == ST_DRIVE && !trip_s) |=> state == ST_DRIVE);

   p_decay_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (en && state == ST_DECAY && !tmr_done) |=> state == ST_DECAY);

   p_expire_redrive_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (en && state == ST_DECAY && tmr_done) |=> state == ST_DRIVE);

   p_start_in_decay_r8: assert property (@(posedge clk) disable iff (!rst_n)
      start_q |-> state == ST_DECAY);

   p_start_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
      start_q |=> !start_q);

endmodule

// File: rtl/chop_ctrl.sv
module chop_ctrl
   import chop_pkg::*;
#(
   parameter int CLK_MHZ     = 50,
   parameter int SYNC_STAGES = 2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       en,
   input  logic       trip_raw,
   input  logic [1:0] toff_code,
   output logic       drive_on,
   output logic       decay_on,
   output logic       idle_on,
   output logic       decay_start
);

   localparam int unsigned MAX_CYC = TOFF_MAX_US * CLK_MHZ;
   localparam int CNT_W = (MAX_CYC > 1) ? $clog2(MAX_CYC) : 1;

   logic     trip_s;
   logic     tmr_done;
   logic     load;
   chop_st_e state;

   chop_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .din   (trip_raw),
      .dout  (trip_s)
   );

   chop_toff_timer #(.CLK_MHZ(CLK_MHZ), .CNT_W(CNT_W)) u_timer (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (!en),
      .load  (load),
      .code  (toff_code),
      .done  (tmr_done)
   );

   chop_fsm u_fsm (
      .clk      (clk),
      .rst_n    (rst_n),
      .en       (en),
      .trip_s   (trip_s),
      .tmr_done (tmr_done),
      .state    (state),
      .load     (load),
      .start_q  (decay_start)
   );

   assign drive_on = (state == ST_DRIVE);
   assign decay_on = (state == ST_DECAY);
   assign idle_on  = (state == ST_IDLE);

   p_bridge_excl_r1: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot({drive_on, decay_on, idle_on}));

   p_start_from_drive_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(decay_on) |-> decay_start);

endmodule

// File: tb/tb_chop_ctrl.sv
module tb_chop_ctrl;

   localparam int MHZ = 50;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       en = 1'b0;
   logic       trip_raw = 1'b0;
   logic [1:0] toff_code = 2'd0;
   logic       drive_on, decay_on, idle_on, decay_start;

   int n_vec = 0;
   int n_bad = 0;
   int exp_q[$];
   int starts = 0;
   int last_drv_len = 0;
   bit finished = 0;

   always #10 clk = ~clk;

   chop_ctrl #(.CLK_MHZ(MHZ)) dut (
      .clk         (clk),
      .rst_n       (rst_n),
      .en          (en),
      .trip_raw    (trip_raw),
      .toff_code   (toff_code),
      .drive_on    (drive_on),
      .decay_on    (decay_on),
      .idle_on     (idle_on),
      .decay_start (decay_start)
   );

   function automatic int cyc_of(input int code);
      case (code)
         0: return 7 * MHZ;
         1: return 16 * MHZ;
         2: return 24 * MHZ;
         default: return 32 * MHZ;
      endcase
   endfunction

   task automatic check(input bit ok, input string req, input int act, input int exp);
      n_vec++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
      end
   endtask

   task automatic step(input int n);
      repeat (n) @(negedge clk);
   endtask

   // Raise trip for four cycles, checking latency and start marker.
   task automatic pulse_trip();
      trip_raw = 1'b1;
      step(2);
      check(drive_on && !decay_on, "R3 drive before sync", int'(decay_on), 0);
      step(1);
      check(decay_on, "R3 decay on third edge", int'(decay_on), 1);
      check(decay_start, "R8 start marker", int'(decay_start), 1);
      step(1);
      trip_raw = 1'b0;
   endtask

   // Monitor: measure each decay period and compare with the queue.
   int  dlen = 0;
   int  drv_len = 0;
   bit  prev_dec = 0;
   always @(negedge clk) begin
      if (rst_n) begin
         if (decay_on && !prev_dec) begin
            dlen = 1;
            starts++;
            last_drv_len = drv_len;
            check(decay_start, "R8 marker at first decay cycle", int'(decay_start), 1);
         end else if (decay_on) begin
            dlen++;
            if (decay_start)
               check(1'b0, "R8 marker repeated", 1, 0);
         end else if (decay_start) begin
            check(1'b0, "R8 marker outside decay", 1, 0);
         end
         if (!decay_on && prev_dec) begin
            int act;
            act = idle_on ? -1 : dlen;
            if (exp_q.size() == 0) begin
               check(1'b0, "R4 unexpected decay", act, 0);
            end else begin
               int e;
               e = exp_q.pop_front();
               check(act == e, "R4/R5 decay length", act, e);
            end
         end
         if (drive_on) drv_len++;
         else          drv_len = 0;
         prev_dec = decay_on;
      end
   end

   initial begin
      step(5);
      check(idle_on && !drive_on && !decay_on && !decay_start, "R1 reset state",
            int'(idle_on), 1);
      rst_n = 1'b1;
      step(2);
      check(idle_on && !drive_on, "R1 idle with en low", int'(idle_on), 1);

      en = 1'b1;
      step(1);
      check(drive_on && !idle_on, "R2 drive after enable", int'(drive_on), 1);
      step(100);
      check(drive_on, "R2 drive holds without trip", int'(drive_on), 1);

      // R5: each off-time code
      for (int c = 0; c < 4; c++) begin
         toff_code = 2'(c);
         exp_q.push_back(cyc_of(c));
         pulse_trip();
         step(cyc_of(c) + 20);
         check(drive_on, "R4 back to drive", int'(drive_on), 1);
      end

      // R6: code change mid-period
      toff_code = 2'd0;
      exp_q.push_back(cyc_of(0));
      pulse_trip();
      step(100);
      toff_code = 2'd3;
      step(cyc_of(0));
      check(drive_on, "R6 period kept old code", int'(drive_on), 1);
      exp_q.push_back(cyc_of(3));
      pulse_trip();
      step(cyc_of(3) + 20);

      // R7: trip held across expiry
      toff_code = 2'd1;
      exp_q.push_back(cyc_of(1));
      exp_q.push_back(cyc_of(1));
      trip_raw = 1'b1;
      step(3 + cyc_of(1) + 1 + cyc_of(1) / 2);
      trip_raw = 1'b0;
      check(last_drv_len == 1, "R7 one drive cycle between decays", last_drv_len, 1);
      step(cyc_of(1));
      check(drive_on, "R7 drive after trip clears", int'(drive_on), 1);

      // R1/R9: disable mid-decay, trip while disabled, full restart
      toff_code = 2'd2;
      exp_q.push_back(-1);
      pulse_trip();
      step(50);
      en = 1'b0;
      step(1);
      check(idle_on && !decay_on && !drive_on, "R1 idle at once on disable",
            int'(idle_on), 1);
      begin
         int s0;
         s0 = starts;
         trip_raw = 1'b1;
         step(10);
         check(idle_on && starts == s0, "R9 trip ignored when disabled", starts, s0);
      end
      trip_raw = 1'b0;
      step(3);
      en = 1'b1;
      step(1);
      check(drive_on, "R2 drive after re-enable", int'(drive_on), 1);
      exp_q.push_back(cyc_of(2));
      pulse_trip();
      step(cyc_of(2) + 20);

      check(exp_q.size() == 0, "R9 all periods observed", exp_q.size(), 0);
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         n_vec++;
         n_bad++;
         $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
         $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
         $finish;
      end
   end

endmodule